// File: doc/BRIEF.md
# Paired GPIO Port Bank

This block holds the control state for five 8-bit general-purpose pin groups. Each pin has its own registered output level, output enable, pull-resistor enable, pull polarity and drive-strength select. These go straight out as control lines to the pad ring. Incoming pin levels pass through a two-stage synchroniser. They can be read back at any time.

The first two pin groups also carry per-pin edge interrupts. Each pin picks a rising or falling trigger, has an enable, and has a sticky flag. One level-sensitive request line summarises all of them. Software reaches the registers over a simple synchronous bus, either one byte per group or as 16-bit words. In a word access, groups 1 and 2 form pair A and groups 3 and 4 form pair B. Group 5 is reachable by byte access only.

Top module: `pio_bank`

## Requirements
- R1: After reset, every output enable, output level, pull enable, pull polarity, drive select, edge select, interrupt enable and flag is 0, and `irq_out` is low.
- R2: A byte write changes only the addressed group's register. Each pin's `pin_oe` and `pin_out` follow its own bit (1 = drive), so any mix of inputs and outputs is possible within a group.
- R3: On all five groups, the pull-enable, pull-polarity (1 = pull up) and drive-select registers appear bit for bit on `pull_en`, `pull_up` and `drive_hi`.
- R4: The address is {kind[3:0], slot[2:0]}, where slot 0..4 selects group 1..5. The kind codes are: 0 input, 1 output level, 2 output enable, 3 pull enable, 4 pull polarity, 5 drive, 6 edge select, 7 interrupt enable, 8 flag. A word access (`bus_word`=1) at slot 0 puts group 1 in bits 7:0 and group 2 in bits 15:8. At slot 2 it puts group 3 low and group 4 high.
- R5: A word access at an odd slot or at slot 4 changes nothing, and a read of it returns 0.
- R6: The input register shows a pin change made before clock edge k only to reads issued from the falling edge after edge k+1 onward. A read issued one cycle earlier still returns the old level.
- R7: With edge select 0 a pin's flag sets on a rising edge, and with edge select 1 it sets on a falling edge. The flag is set after the third rising clock edge following the pin change.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An edge that sets a flag in the same cycle as a clearing write wins.
- R9: `irq_out` is high exactly when some flag is 1 and its interrupt enable is 1.
- R10: Groups 3 to 5 have no interrupt logic. Their edge-select, enable and flag kinds read 0, writes to them are ignored, and their pins never raise `irq_out`.
- R11: Writing a pin's edge-select bit never sets that pin's flag by itself.
- R12: Read data is registered. It is valid from the falling edge after the clock edge that sampled the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit paired access |
| bus_addr | input | 7 | {kind, slot} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 40 | Pin levels from pads, group 1 in bits 7:0 |
| pin_out | output | 40 | Output levels |
| pin_oe | output | 40 | Output enables |
| pull_en | output | 40 | Pull resistor enables |
| pull_up | output | 40 | Pull polarity, 1 = up |
| drive_hi | output | 40 | High drive strength select |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two events can meet in the same clock edge: an edge detected on a pin, and a bus write that clears that pin's flag. The bench changes a pin, waits two cycles, and then times a zero write to the flag register so that it lands on the very edge where the synchronised transition sets the flag. It then reads the flag back through the bus and expects it set, with the other cleared bits still 0. A second near-collision comes from rewriting an edge select while the pin is held steady. That case is judged by the flag and `irq_out` staying low.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_CNT     = 5;
  localparam int PORT_BITS    = 8;
  localparam int IRQ_PORT_CNT = 2;
  localparam int PAIRED_PORTS = 4;
  localparam int SLOT_W       = 3;
  localparam int KIND_W       = 4;

  typedef enum logic [KIND_W-1:0] {
    K_IN  = 4'd0,
    K_OUT = 4'd1,
    K_DIR = 4'd2,
    K_PEN = 4'd3,
    K_PUP = 4'd4,
    K_DRV = 4'd5,
    K_EDG = 4'd6,
    K_IEN = 4'd7,
    K_FLG = 4'd8
  } reg_kind_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pio_busdec.sv
module pio_busdec #(
  parameter int N_PORTS = 5,
  parameter int N_PAIRED = 4,
  parameter int SLOT_W  = 3
) (
  input  logic              sel,
  input  logic              word,
  input  logic [SLOT_W-1:0] slot,
  output logic [N_PORTS-1:0] hit,
  output logic [N_PORTS-1:0] hi_lane
);
  function automatic logic pair_base_ok(input logic [SLOT_W-1:0] s);
    return (s[0] == 1'b0) && (int'(s) + 1 < N_PAIRED);
  endfunction

  always_comb begin
    hit     = '0;
    hi_lane = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (sel) begin
        if (!word) begin
          hit[p] = (int'(slot) == p);
        end else if (pair_base_ok(slot)) begin
          if (int'(slot) == p) hit[p] = 1'b1;
          if (int'(slot) + 1 == p) begin
            hit[p]     = 1'b1;
            hi_lane[p] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HAS_IRQ = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  reg_kind_e kind,
  input  logic [W-1:0] wbyte,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pen_q,
  output logic [W-1:0] pup_q,
  output logic [W-1:0] drv_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] evt,
  output logic [W-1:0] rbyte
);
  logic [W-1:0] es_q;

  // Per pin: rising when sel=0, falling when sel=1.
  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] prev,
                                             input logic [W-1:0] cur,
                                             input logic [W-1:0] sel);
    return (~sel & cur & ~prev) | (sel & prev & ~cur);
  endfunction

  // A zero written to a flag clears it; a new edge always wins.
  function automatic logic [W-1:0] merge_flags(input logic [W-1:0] old,
                                               input logic         clr_we,
                                               input logic [W-1:0] wmask,
                                               input logic [W-1:0] hits);
    return (clr_we ? (old & wmask) : old) | hits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      pen_q <= '0;
      pup_q <= '0;
      drv_q <= '0;
    end else if (we) begin
      case (kind)
        K_OUT:   out_q <= wbyte;
        K_DIR:   dir_q <= wbyte;
        K_PEN:   pen_q <= wbyte;
        K_PUP:   pup_q <= wbyte;
        K_DRV:   drv_q <= wbyte;
        default: ;
      endcase
    end
  end

  generate
    if (HAS_IRQ) begin : g_irq
      logic [W-1:0] prev_q;
      assign evt = edge_hits(prev_q, pin_sync, es_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          es_q   <= '0;
          ien_q  <= '0;
          flag_q <= '0;
          prev_q <= '0;
        end else begin
          prev_q <= pin_sync;
          if (we && kind == K_EDG) es_q  <= wbyte;
          if (we && kind == K_IEN) ien_q <= wbyte;
          flag_q <= merge_flags(flag_q, we && kind == K_FLG, wbyte, evt);
        end
      end
    end else begin : g_noirq
      assign es_q   = '0;
      assign ien_q  = '0;
      assign flag_q = '0;
      assign evt    = '0;
    end
  endgenerate

  always_comb begin
    case (kind)
      K_IN:    rbyte = pin_sync;
      K_OUT:   rbyte = out_q;
      K_DIR:   rbyte = dir_q;
      K_PEN:   rbyte = pen_q;
      K_PUP:   rbyte = pup_q;
      K_DRV:   rbyte = drv_q;
      K_EDG:   rbyte = es_q;
      K_IEN:   rbyte = ien_q;
      K_FLG:   rbyte = flag_q;
      default: rbyte = '0;
    endcase
  end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter  int N_PORTS   = PORT_CNT,
  parameter  int PORT_W    = PORT_BITS,
  parameter  int IRQ_PORTS = IRQ_PORT_CNT,
  parameter  int PAIRED    = PAIRED_PORTS,
  localparam int ADDR_W    = KIND_W + SLOT_W,
  localparam int PINS      = N_PORTS * PORT_W,
  localparam int DATA_W    = 2 * PORT_W,
  localparam int FLAG_BITS = IRQ_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pull_en,
  output logic [PINS-1:0]   pull_up,
  output logic [PINS-1:0]   drive_hi,
  output logic              irq_out
);
  reg_kind_e         kind;
  logic [SLOT_W-1:0] slot;
  logic [N_PORTS-1:0] hit, hi_lane;
  logic [PINS-1:0]    in_sync;
  logic               wr_any, flag_wr;
  logic [FLAG_BITS-1:0] flags, iens, edge_evt;
  logic [PORT_W-1:0]  rbyte  [N_PORTS];
  logic [PORT_W-1:0]  ien_p  [N_PORTS];
  logic [PORT_W-1:0]  flag_p [N_PORTS];
  logic [PORT_W-1:0]  evt_p  [N_PORTS];
  logic [DATA_W-1:0]  rd_n;

  assign kind    = reg_kind_e'(bus_addr[ADDR_W-1:SLOT_W]);
  assign slot    = bus_addr[SLOT_W-1:0];
  assign wr_any  = bus_sel & bus_wr;
  assign flag_wr = wr_any && (kind == K_FLG);

  pio_busdec #(.N_PORTS(N_PORTS), .N_PAIRED(PAIRED), .SLOT_W(SLOT_W)) u_dec (
    .sel(bus_sel), .word(bus_word), .slot(slot), .hit(hit), .hi_lane(hi_lane)
  );

  pio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] wbyte;
      assign wbyte = hi_lane[p] ? bus_wdata[DATA_W-1:PORT_W] : bus_wdata[PORT_W-1:0];

      pio_port #(.W(PORT_W), .HAS_IRQ(p < IRQ_PORTS)) u_port (
        .clk(clk), .rst_n(rst_n),
        .we(hit[p] & bus_wr), .kind(kind), .wbyte(wbyte),
        .pin_sync(in_sync[p*PORT_W +: PORT_W]),
        .out_q(pin_out[p*PORT_W +: PORT_W]),
        .dir_q(pin_oe[p*PORT_W +: PORT_W]),
        .pen_q(pull_en[p*PORT_W +: PORT_W]),
        .pup_q(pull_up[p*PORT_W +: PORT_W]),
        .drv_q(drive_hi[p*PORT_W +: PORT_W]),
        .ien_q(ien_p[p]), .flag_q(flag_p[p]), .evt(evt_p[p]),
        .rbyte(rbyte[p])
      );

      if (p < IRQ_PORTS) begin : g_irqmap
        assign flags[p*PORT_W +: PORT_W]    = flag_p[p];
        assign iens[p*PORT_W +: PORT_W]     = ien_p[p];
        assign edge_evt[p*PORT_W +: PORT_W] = evt_p[p];
      end
    end
  endgenerate

  always_comb begin
    rd_n = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (hit[p]) begin
        if (hi_lane[p]) rd_n[DATA_W-1:PORT_W] = rbyte[p];
        else            rd_n[PORT_W-1:0]      = rbyte[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_sel & ~bus_wr) bus_rdata <= rd_n;
  end

  assign irq_out = |(flags & iens);
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int PINS  = 40,
  parameter int FLAGS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PINS-1:0]  pin_in,
  input logic [PINS-1:0]  in_sync,
  input logic [PINS-1:0]  pin_oe,
  input logic             wr_any,
  input logic             flag_wr,
  input logic [FLAGS-1:0] flags,
  input logic [FLAGS-1:0] edge_evt,
  input logic [FLAGS-1:0] iens,
  input logic             irq_out
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (in_sync == $past(pin_in, 2)));                         // R6

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(edge_evt)) == '0));                         // R7

  AST_FLAG_CLEARS_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~flags) != '0) |-> $past(flag_wr));                        // R8

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((iens != '0) && (flags != '0)));                                // R9

  AST_OE_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_any) |-> $stable(pin_oe));                                         // R2
endmodule

bind pio_bank pio_bank_chk #(.PINS(PINS), .FLAGS(FLAG_BITS)) u_pio_bank_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_sync(in_sync),
  .pin_oe(pin_oe), .wr_any(wr_any), .flag_wr(flag_wr), .flags(flags),
  .edge_evt(edge_evt), .iens(iens), .irq_out(irq_out)
);

// File: tb/test_pio_bank.sv
`timescale 1ns/1ps
module test_pio_bank;
  import pio_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [39:0] pin_in = '0;
  logic [39:0] pin_out, pin_oe, pull_en, pull_up, drive_hi;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_due = 1'b0;
  bit          finished = 1'b0;

  pio_bank i_pio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up),
    .drive_hi(drive_hi), .irq_out(irq_out)
  );

  function automatic logic [6:0] ad(input reg_kind_e k, input int s);
    logic [2:0] s3;
    s3 = s[2:0];
    return {k, s3};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic wr(input reg_kind_e k, input int s, input bit word, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = ad(k, s); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input reg_kind_e k, input int s, input bit word,
                    input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = ad(k, s);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Monitor: one read result per sampled read, due one edge later (R12).
  always @(posedge clk) rd_due <= bus_sel & ~bus_wr;

  always @(negedge clk) begin
    if (rd_due) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected read", 64'(bus_rdata), 64'hDEAD);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    check("watchdog expired", 64'd1, 64'd0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 pull_en", pull_en, 0);
    check("R1 pull_up", pull_up, 0);
    check("R1 drive_hi", drive_hi, 0);
    check("R1 irq_out", irq_out, 0);
    rd(K_FLG, 0, 1, 16'h0000, "R1 flags");
    rd(K_IEN, 0, 1, 16'h0000, "R1 enables");

    // R2 byte writes, mixed directions in one group
    wr(K_DIR, 2, 0, 16'h00A5);
    check("R2 pin_oe group3", pin_oe, 40'h0000A50000);
    wr(K_OUT, 2, 0, 16'h003C);
    check("R2 pin_out group3", pin_out, 40'h00003C0000);
    rd(K_DIR, 2, 0, 16'h00A5, "R2 dir readback");

    // R3 pulls and drive on several groups
    wr(K_PEN, 4, 0, 16'h00F0);
    wr(K_PUP, 4, 0, 16'h000F);
    wr(K_DRV, 0, 0, 16'h0081);
    check("R3 pull_en", pull_en, 40'hF000000000);
    check("R3 pull_up", pull_up, 40'h0F00000000);
    check("R3 drive_hi", drive_hi, 40'h0000000081);

    // R4 paired word access
    wr(K_DIR, 0, 1, 16'h1234);
    check("R4 pair A dir", pin_oe, 40'h0000A51234);
    rd(K_DIR, 0, 1, 16'h1234, "R4 pair A read");
    wr(K_OUT, 2, 1, 16'hBEEF);
    check("R4 pair B out", pin_out, 40'h00BEEF0000);
    rd(K_OUT, 3, 0, 16'h00BE, "R4 group4 byte");

    // R5 word access at odd slot or slot 4
    wr(K_DIR, 4, 1, 16'hFFFF);
    wr(K_DIR, 1, 1, 16'hFFFF);
    check("R5 ignored word writes", pin_oe, 40'h0000A51234);
    rd(K_DIR, 1, 1, 16'h0000, "R5 odd slot read");
    rd(K_OUT, 4, 1, 16'h0000, "R5 slot4 word read");

    // R12 read latency
    wr(K_OUT, 4, 0, 16'h0099);
    check("R12 pin_out group5", pin_out[39:32], 8'h99);
    rd(K_OUT, 4, 0, 16'h0099, "R12 byte read");

    // R6 synchroniser depth
    pin_in[31:24] = 8'h77;
    @(negedge clk);
    rd(K_IN, 3, 0, 16'h0000, "R6 still old");
    rd(K_IN, 3, 0, 16'h0077, "R6 new level");

    // R7 rising edge with select 0
    wr(K_IEN, 0, 0, 16'h0003);
    wr(K_EDG, 0, 0, 16'h0002);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 no flag after two edges", irq_out, 0);
    @(negedge clk);
    check("R7 rising flag on third edge", irq_out, 1);
    wr(K_FLG, 0, 0, 16'h0000);
    check("R8 clear drops irq", irq_out, 0);

    // R7 falling edge with select 1
    pin_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 rising ignored when falling selected", irq_out, 0);
    rd(K_FLG, 0, 0, 16'h0000, "R7 no flag on rise");
    pin_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 falling sets irq", irq_out, 1);
    rd(K_FLG, 0, 0, 16'h0002, "R7 falling flag");

    // R8 sticky flags
    wr(K_FLG, 0, 0, 16'h00FF);
    rd(K_FLG, 0, 0, 16'h0002, "R8 writing ones keeps");
    wr(K_FLG, 0, 0, 16'h0000);
    rd(K_FLG, 0, 0, 16'h0000, "R8 writing zero clears");

    // R8 collision: clear lands on the edge that sets bit 2
    pin_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(K_FLG, 0, 0, 16'h0000);
    rd(K_FLG, 0, 0, 16'h0004, "R8 edge beats clear");

    // R9 enable gating
    check("R9 flag without enable", irq_out, 0);
    wr(K_IEN, 0, 0, 16'h0004);
    check("R9 enable raises irq", irq_out, 1);
    wr(K_FLG, 0, 0, 16'h0000);
    check("R9 cleared flag drops irq", irq_out, 0);

    // R11 edge select rewrite with steady high pin
    wr(K_EDG, 0, 0, 16'h0006);
    repeat (3) @(negedge clk);
    rd(K_FLG, 0, 0, 16'h0000, "R11 select write sets no flag");
    check("R11 irq stays low", irq_out, 0);

    // R4 flag through a word read: group 2 bit 0
    pin_in[8] = 1'b1;
    repeat (4) @(negedge clk);
    rd(K_FLG, 0, 1, 16'h0100, "R4 pair A flag word");

    // R10 groups without interrupt logic
    wr(K_IEN, 2, 0, 16'h00FF);
    wr(K_EDG, 2, 0, 16'h00FF);
    rd(K_IEN, 2, 0, 16'h0000, "R10 enable reads zero");
    rd(K_EDG, 2, 0, 16'h0000, "R10 select reads zero");
    pin_in[16] = 1'b1;
    pin_in[39] = 1'b1;
    repeat (4) @(negedge clk);
    rd(K_FLG, 2, 1, 16'h0000, "R10 pair B flags zero");
    rd(K_FLG, 4, 0, 16'h0000, "R10 group5 flags zero");
    check("R10 no irq", irq_out, 0);

    @(negedge clk);
    check("R12 all reads returned", 64'(exp_q.size()), 0);
    finish_up();
  end
endmodule